// File: doc/BRIEF.md
# Almost-regular permutation address generator

This block produces the interleaved address sequence of an almost-regular permutation, as used by a duo-binary turbo decoder. It needs no address table and no multiplier. A start pulse captures the block length N (counted in couples) and four permutation constants. From then on the block presents one address per step, P(0), P(1), ... P(N-1). The consumer moves to the next address by raising an advance strobe.

Each address is the linear term (P0·i) mod N plus one plus an offset. The offset is picked by i mod 4 and is one of:

- zero
- N/2 + P1
- P2
- N/2 + P3

The linear term sits in an accumulator. Each step adds P0 to it, followed by a single conditional subtraction of N. The two odd-phase offsets are reduced modulo N once, when the start pulse is taken. The output sum is then brought back into range by two conditional subtractions.

N must be even and lie between 24 and 2400. Each of P0..P3 must be below N.

Top module: `arp_addr_gen`

## Requirements
- R1: Reset clears valid and last. In the cycle after start is sampled high, valid is 1 and addr shows P(0) = 1.
- R2: For an index i with i mod 4 = 0, addr equals (P0·i + 1) mod N.
- R3: For an index i with i mod 4 = 1, addr equals (P0·i + 1 + N/2 + P1) mod N.
- R4: For i mod 4 = 2, addr equals (P0·i + 1 + P2) mod N. For i mod 4 = 3, addr equals (P0·i + 1 + N/2 + P3) mod N.
- R5: Whenever valid is high, addr is below N. This also holds for N = 2400 with all four constants at N-1.
- R6: An edge where valid and adv are both high moves the output to the next index. With adv low, addr holds its value.
- R7: last is high exactly while the address for i = N-1 is shown. An advance taken on that address drops valid and last in the next cycle.
- R8: While valid is low, adv has no effect: valid and last stay low.
- R9: start restarts the sequence at i = 0 even in the middle of a block. When start and adv are high in the same cycle, start wins and the advance is discarded.
- R10: blk_len and p0..p3 are sampled only on the start cycle. Changing them during a block leaves the running sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new block and capture the configuration |
| adv | input | 1 | Step to the next index |
| blk_len | input | NW | Block length N in couples (even, 24..2400) |
| p0 | input | NW | Linear step constant |
| p1 | input | NW | Offset constant for i mod 4 = 1 |
| p2 | input | NW | Offset constant for i mod 4 = 2 |
| p3 | input | NW | Offset constant for i mod 4 = 3 |
| addr | output | NW | Interleaved address P(i) |
| valid | output | 1 | addr holds a live address |
| last | output | 1 | addr is the final index N-1 |

## Verification
Two events can fall in the same cycle: a restart and an advance, when start and adv are both high. The bench provokes this by aborting a block partway through while it is being advanced continuously, and raising adv together with the new start. The check is that the first address seen afterwards is P(0) of the new block, and that the following addresses match the new block's sequence with no index skipped.

The other coincidence is the final address meeting an advance. There, valid has to fall cleanly in the next cycle, and no extra address may appear.

// File: rtl/arp_pkg.sv
package arp_pkg;

  localparam int unsigned ARP_WMAX = 16;

  typedef logic [ARP_WMAX-1:0] arp_word_t;

  // Sum of two residues below n, folded back below n with one subtraction.
  function automatic arp_word_t mod_add(arp_word_t a, arp_word_t b, arp_word_t n);
    logic [ARP_WMAX:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[ARP_WMAX-1:0];
  endfunction

endpackage

// File: rtl/arp_offsets.sv
module arp_offsets
  import arp_pkg::*;
#(
  parameter int unsigned NW = 12
) (
  input  logic [NW-1:0] blk_len,
  input  logic [NW-1:0] p1,
  input  logic [NW-1:0] p2,
  input  logic [NW-1:0] p3,
  output logic [NW-1:0] off [4]
);

  logic [NW-1:0] half;
  assign half = blk_len >> 1;

  for (genvar k = 0; k < 4; k++) begin : g_off
    if (k == 0) begin : g_zero
      assign off[k] = '0;
    end else if (k == 2) begin : g_plain
      assign off[k] = p2;
    end else begin : g_half
      logic [NW-1:0] pk;
      assign pk     = (k == 1) ? p1 : p3;
      assign off[k] = NW'(mod_add(arp_word_t'(half), arp_word_t'(pk), arp_word_t'(blk_len)));
    end
  end

endmodule

// File: rtl/arp_walker.sv
module arp_walker
  import arp_pkg::*;
#(
  parameter int unsigned NW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic [NW-1:0] n_q,
  input  logic [NW-1:0] p0_q,
  output logic [NW-1:0] acc,
  output logic [1:0]    phase,
  output logic          valid,
  output logic          last,
  output logic          step_fire
);

  logic [NW-1:0] idx;
  logic          at_end;

  assign at_end    = (idx == n_q - NW'(1));
  assign last      = valid && at_end;
  assign step_fire = valid && adv && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      phase <= '0;
      idx   <= '0;
      valid <= 1'b0;
    end else if (start) begin
      acc   <= '0;
      phase <= '0;
      idx   <= '0;
      valid <= 1'b1;
    end else if (step_fire) begin
      acc   <= NW'(mod_add(arp_word_t'(acc), arp_word_t'(p0_q), arp_word_t'(n_q)));
      phase <= phase + 2'd1;
      idx   <= idx + NW'(1);
      if (at_end) valid <= 1'b0;
    end
  end

endmodule

// File: rtl/arp_combine.sv
module arp_combine
  import arp_pkg::*;
#(
  parameter int unsigned NW = 12
) (
  input  logic [NW-1:0] acc,
  input  logic [NW-1:0] off_sel,
  input  logic [NW-1:0] n_q,
  output logic [NW-1:0] addr
);

  logic [NW-1:0] part;

  // Two folding stages: first acc + offset, then + 1.
  assign part = NW'(mod_add(arp_word_t'(acc), arp_word_t'(off_sel), arp_word_t'(n_q)));
  assign addr = NW'(mod_add(arp_word_t'(part), arp_word_t'(1), arp_word_t'(n_q)));

endmodule

// File: rtl/arp_addr_gen.sv
module arp_addr_gen
  import arp_pkg::*;
#(
  parameter int unsigned NW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic [NW-1:0] blk_len,
  input  logic [NW-1:0] p0,
  input  logic [NW-1:0] p1,
  input  logic [NW-1:0] p2,
  input  logic [NW-1:0] p3,
  output logic [NW-1:0] addr,
  output logic          valid,
  output logic          last
);

  logic [NW-1:0] n_q;
  logic [NW-1:0] p0_q;
  logic [NW-1:0] off_d [4];
  logic [NW-1:0] off_q [4];
  logic [NW-1:0] acc;
  logic [1:0]    phase;
  logic          step_fire;

  arp_offsets #(.NW(NW)) u_offsets (
    .blk_len (blk_len),
    .p1      (p1),
    .p2      (p2),
    .p3      (p3),
    .off     (off_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q  <= NW'(2);
      p0_q <= '0;
      for (int k = 0; k < 4; k++) off_q[k] <= '0;
    end else if (start) begin
      n_q  <= blk_len;
      p0_q <= p0;
      for (int k = 0; k < 4; k++) off_q[k] <= off_d[k];
    end
  end

  arp_walker #(.NW(NW)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .adv       (adv),
    .n_q       (n_q),
    .p0_q      (p0_q),
    .acc       (acc),
    .phase     (phase),
    .valid     (valid),
    .last      (last),
    .step_fire (step_fire)
  );

  arp_combine #(.NW(NW)) u_combine (
    .acc     (acc),
    .off_sel (off_q[phase]),
    .n_q     (n_q),
    .addr    (addr)
  );

endmodule

// File: rtl/arp_addr_gen_chk.sv
module arp_addr_gen_chk #(
  parameter int unsigned NW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          adv,
  input logic          valid,
  input logic          last,
  input logic [NW-1:0] addr,
  input logic [NW-1:0] n_q,
  input logic [1:0]    phase,
  input logic          step_fire
);

  p_start_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (valid && addr == NW'(1)));

  p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (addr < n_q));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !adv && !start) |=> $stable(addr));

  p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> (phase == $past(phase) + 2'd1));

  p_last_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  p_drop_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && adv && !start) |=> (!valid && !last));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !start) |=> !valid);

  p_start_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && adv) |=> (phase == 2'd0));

endmodule

bind arp_addr_gen arp_addr_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .adv       (adv),
  .valid     (valid),
  .last      (last),
  .addr      (addr),
  .n_q       (n_q),
  .phase     (phase),
  .step_fire (step_fire)
);

// File: tb/arp_addr_gen_tb.sv
module arp_addr_gen_tb;

  localparam int NW = 12;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          adv = 1'b0;
  logic [NW-1:0] blk_len = '0;
  logic [NW-1:0] p0 = '0, p1 = '0, p2 = '0, p3 = '0;
  logic [NW-1:0] addr;
  logic          valid, last;

  int checks = 0;
  int fails  = 0;
  int q_addr [$];
  int q_idx  [$];
  bit q_last [$];
  int cur_n = 2;

  always #(CLK_PERIOD/2) clk = ~clk;

  arp_addr_gen #(.NW(NW)) u_dut (
    .clk (clk), .rst_n (rst_n), .start (start), .adv (adv),
    .blk_len (blk_len), .p0 (p0), .p1 (p1), .p2 (p2), .p3 (p3),
    .addr (addr), .valid (valid), .last (last)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_addr(int n, int a0, int a1, int a2, int a3, int i);
    longint v;
    v = longint'(a0) * i + 1;
    case (i % 4)
      1: v = v + n / 2 + a1;
      2: v = v + a2;
      3: v = v + n / 2 + a3;
      default: ;
    endcase
    return int'(v % n);
  endfunction

  // Monitor: compares consumed and held addresses with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && valid && !start) begin
      if (q_addr.size() == 0) begin
        chk(1'b0, "R7 unexpected address", int'(addr), -1);
      end else begin
        string tag;
        tag = (q_idx[0] % 4 == 0) ? "R2" : (q_idx[0] % 4 == 1) ? "R3" : "R4";
        if (adv) begin
          chk(int'(addr) == q_addr[0], {tag, " with R10 inputs changed"}, int'(addr), q_addr[0]);
          chk(last == q_last[0], "R7 last flag", int'(last), int'(q_last[0]));
          chk(int'(addr) < cur_n, "R5 range", int'(addr), cur_n);
          void'(q_addr.pop_front());
          void'(q_idx.pop_front());
          void'(q_last.pop_front());
        end else begin
          chk(int'(addr) == q_addr[0], "R6 hold without adv", int'(addr), q_addr[0]);
        end
      end
    end
  end

  task automatic run_block(int n, int a0, int a1, int a2, int a3,
                           int mode, int stop_left, bit adv_with_start);
    int cyc = 0;
    @(posedge clk); #1;
    q_addr.delete(); q_idx.delete(); q_last.delete();
    start = 1'b1; adv = adv_with_start;
    blk_len = NW'(n); p0 = NW'(a0); p1 = NW'(a1); p2 = NW'(a2); p3 = NW'(a3);
    cur_n = n;
    for (int i = 0; i < n; i++) begin
      q_addr.push_back(ref_addr(n, a0, a1, a2, a3, i));
      q_idx.push_back(i);
      q_last.push_back(i == n - 1);
    end
    @(posedge clk); #1;
    start = 1'b0;
    // R10: scramble configuration inputs while the block runs
    blk_len = NW'(100); p0 = NW'(7); p1 = NW'(3); p2 = NW'(9); p3 = NW'(11);
    adv = (mode == 0) ? 1'b1 : 1'b0;
    @(negedge clk);
    chk(valid === 1'b1 && int'(addr) == 1,
        adv_with_start ? "R9 restart with adv" : "R1 first address", int'(addr), 1);
    while (q_addr.size() > stop_left) begin
      @(posedge clk); #1;
      cyc++;
      adv = (mode == 0) ? 1'b1 : (cyc % 3 != 0);
      @(negedge clk);
    end
    @(posedge clk); #1;
    adv = 1'b0;
    if (stop_left == 0) begin
      @(negedge clk);
      chk(!valid && !last, "R7 valid drops after last", int'(valid), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!valid && !last, "R1 reset state", int'(valid), 0);
    #1 rst_n = 1'b1;

    run_block(24, 5, 0, 0, 0, 0, 0, 1'b0);
    run_block(48, 13, 24, 4, 8, 1, 0, 1'b0);
    run_block(26, 25, 13, 1, 0, 1, 0, 1'b0);
    run_block(2400, 2399, 2399, 2399, 2399, 0, 0, 1'b0);

    // R8: advance strobes while idle
    @(posedge clk); #1; adv = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!valid && !last, "R8 adv ignored when idle", int'(valid), 0);
    end
    @(posedge clk); #1; adv = 1'b0;

    // R9: abort mid-block, restart with adv high in the start cycle
    run_block(36, 11, 5, 17, 2, 0, 20, 1'b0);
    run_block(40, 7, 3, 30, 21, 0, 0, 1'b1);

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule